// File: doc/BRIEF.md
# Four-Level Priority Interrupt Controller

This block chooses which of seven interrupt sources a small 8-bit core services next. The sources are two external lines, two timers, a serial port, a general-purpose source and an analog comparator. Software-owned registers arrive as plain inputs:
- an enable word, with one bit per source and a master bit;
- a low-level word and a high-level word, which together give each of the first six sources a 2-bit level.

The comparator has no level bits and always sits at level 0.

The core raises a strobe at the end of every instruction. On that strobe the controller selects the best eligible request. It takes the request only if no routine is running, or if the request's level is strictly above the level of the routine now running. When it takes a request it pulses a vector request, reports the source index and the routine's entry address, and pushes the new level onto a small in-service stack. A return-from-interrupt pulse from the core pops that stack, which restores the level of the routine that was interrupted.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Source indices are 0 external-A, 1 timer-A, 2 external-B, 3 timer-B, 4 serial, 5 general-purpose, 6 comparator. A taken request reports its index on `src_o` and the address 0x0003 + 8 × index on `vec_o`.
- R2: A request counts only when its own bit `en_i[i]` is 1 and the master bit `en_i[7]` is 1.
- R3: Source i (0 to 5) has level {`hi_i[i]`, `lo_i[i]`}, where 3 is the highest. The comparator (index 6) is always at level 0.
- R4: Selection happens only in a cycle where `boundary_i` is high. The clock edge that ends that cycle sets `vec_req_o` high for one cycle, with `src_o` and `vec_o` valid at the same time.
- R5: Among eligible requests, the highest level wins. Between requests of equal level, the lower index wins.
- R6: The winner is taken only if the stack is empty or its level is strictly greater than `cur_lvl_o`. Requests of equal or lower level stay pending.
- R7: While a level-3 routine is in service, no request is taken.
- R8: Each acceptance pushes the winner's level: `depth_o` goes up by one and `cur_lvl_o` shows that level. A `reti_i` pulse pops one entry. When `depth_o` is 0, `busy_o` is 0 and `cur_lvl_o` is 0.
- R9: If `reti_i` and `boundary_i` are high in the same cycle, the pop happens and no request is taken in that cycle.
- R10: After reset, `vec_req_o`, `src_o`, `vec_o`, `cur_lvl_o`, `depth_o` and `busy_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 7 | Pending request flags, one per source |
| en_i | input | 8 | Per-source enables in bits 6:0, master enable in bit 7 |
| lo_i | input | 6 | Low bit of the level for sources 0 to 5 |
| hi_i | input | 6 | High bit of the level for sources 0 to 5 |
| boundary_i | input | 1 | Instruction-boundary strobe |
| reti_i | input | 1 | Return-from-interrupt pulse |
| vec_req_o | output | 1 | One-cycle vector request |
| src_o | output | 3 | Index of the source taken |
| vec_o | output | 16 | Entry address of the taken source |
| cur_lvl_o | output | 2 | Level at the top of the in-service stack |
| depth_o | output | 3 | Number of routines in service |
| busy_o | output | 1 | A routine is in service |

## Verification
The hardest state to reach is a full four-deep nest. It needs one acceptance at each level in rising order, and requests of equal and lower level must be held pending at every step without being taken. The stimulus first sets the two level words so that four sources sit at distinct levels. It then strobes requests in the order 0, 1, 2, 3, mixing in equal-level and lower-level requests along the way to show they are refused. Once the stack is full, it unwinds the nest one return at a time and checks the level that each pop restores. A return that arrives in the same cycle as a strobe is also driven while a routine is in service, to show the pop wins and nothing is taken.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC      = 7;
  localparam int LVLW      = 2;
  localparam int NLVL      = 1 << LVLW;
  localparam int IDXW      = $clog2(NSRC);
  localparam int DEPW      = $clog2(NLVL + 1);
  localparam int ADDRW     = 16;
  localparam int VEC_SHIFT = 3;
  localparam logic [ADDRW-1:0] VEC_BASE = 16'h0003;

  typedef logic [LVLW-1:0] lvl_t;
  typedef logic [IDXW-1:0] idx_t;
endpackage

// File: rtl/irq_level_map.sv
module irq_level_map
  import irq_pkg::*;
(
  input  logic [NSRC-2:0]           lo_i,
  input  logic [NSRC-2:0]           hi_i,
  output logic [NSRC-1:0][LVLW-1:0] lvl_o
);
  // Sources with level bits take them from the split registers
  for (genvar g = 0; g < NSRC - 1; g++) begin : g_prog
    assign lvl_o[g] = {hi_i[g], lo_i[g]};
  end
  // Last source is pinned to the lowest level
  assign lvl_o[NSRC-1] = '0;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic [NSRC-1:0]           elig_i,
  input  logic [NSRC-1:0][LVLW-1:0] lvl_i,
  output logic                      found_o,
  output idx_t                      win_idx_o,
  output lvl_t                      win_lvl_o
);
  // Scan from the highest index downward; ">=" lets a lower index
  // displace an equal-level winner, so ties go to the lower index.
  always_comb begin
    found_o   = 1'b0;
    win_idx_o = '0;
    win_lvl_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig_i[i] && (!found_o || lvl_i[i] >= win_lvl_o)) begin
        found_o   = 1'b1;
        win_idx_o = IDXW'(i);
        win_lvl_o = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_i,
  input  logic            pop_i,
  input  lvl_t            push_lvl_i,
  output lvl_t            top_o,
  output logic [DEPW-1:0] depth_o,
  output logic            busy_o
);
  logic [NLVL-1:0][LVLW-1:0] ent_q, ent_d;
  logic [DEPW-1:0]           cnt_q, cnt_d;
  logic                      upd;

  assign upd = push_i | pop_i;

  always_comb begin
    ent_d = ent_q;
    cnt_d = cnt_q;
    if (push_i) begin
      for (int i = NLVL - 1; i > 0; i--) ent_d[i] = ent_q[i-1];
      ent_d[0] = push_lvl_i;
      cnt_d    = cnt_q + 1'b1;
    end else if (pop_i) begin
      for (int i = 0; i < NLVL - 1; i++) ent_d[i] = ent_q[i+1];
      ent_d[NLVL-1] = '0;
      cnt_d         = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q <= '0;
      cnt_q <= '0;
    end else if (upd) begin
      ent_q <= ent_d;
      cnt_q <= cnt_d;
    end
  end

  assign top_o   = ent_q[0];
  assign depth_o = cnt_q;
  assign busy_o  = (cnt_q != '0);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      req_i,
  input  logic [NSRC:0]        en_i,
  input  logic [NSRC-2:0]      lo_i,
  input  logic [NSRC-2:0]      hi_i,
  input  logic                 boundary_i,
  input  logic                 reti_i,
  output logic                 vec_req_o,
  output logic [IDXW-1:0]      src_o,
  output logic [ADDRW-1:0]     vec_o,
  output logic [LVLW-1:0]      cur_lvl_o,
  output logic [DEPW-1:0]      depth_o,
  output logic                 busy_o
);
  logic [NSRC-1:0][LVLW-1:0] lvl;
  logic [NSRC-1:0]           elig;
  logic                      found;
  idx_t                      win_idx;
  lvl_t                      win_lvl;
  lvl_t                      top_lvl;
  logic                      busy;
  logic                      take;
  logic                      pop;

  logic                      vreq_q, vreq_d;
  idx_t                      src_q, src_d;
  logic [ADDRW-1:0]          vec_q, vec_d;

  irq_level_map u_map (
    .lo_i  (lo_i),
    .hi_i  (hi_i),
    .lvl_o (lvl)
  );

  assign elig = req_i & en_i[NSRC-1:0] & {NSRC{en_i[NSRC]}};

  irq_arbiter u_arb (
    .elig_i    (elig),
    .lvl_i     (lvl),
    .found_o   (found),
    .win_idx_o (win_idx),
    .win_lvl_o (win_lvl)
  );

  // A return occupies the boundary; acceptance needs strict precedence
  assign take = boundary_i & ~reti_i & found & (~busy | (win_lvl > top_lvl));
  assign pop  = reti_i & busy;

  irq_lvl_stack u_stk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (take),
    .pop_i      (pop),
    .push_lvl_i (win_lvl),
    .top_o      (top_lvl),
    .depth_o    (depth_o),
    .busy_o     (busy)
  );

  always_comb begin
    vreq_d = take;
    src_d  = src_q;
    vec_d  = vec_q;
    if (take) begin
      src_d = win_idx;
      vec_d = VEC_BASE + (ADDRW'(win_idx) << VEC_SHIFT);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vreq_q <= 1'b0;
    else        vreq_q <= vreq_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      vec_q <= '0;
    end else if (take) begin
      src_q <= src_d;
      vec_q <= vec_d;
    end
  end

  assign vec_req_o = vreq_q;
  assign src_o     = src_q;
  assign vec_o     = vec_q;
  assign cur_lvl_o = top_lvl;
  assign busy_o    = busy;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic [NSRC-1:0]      req_i,
  input logic [NSRC:0]        en_i,
  input logic                 boundary_i,
  input logic                 reti_i,
  input logic                 vec_req_o,
  input logic [IDXW-1:0]      src_o,
  input logic [ADDRW-1:0]     vec_o,
  input logic [LVLW-1:0]      cur_lvl_o,
  input logic [DEPW-1:0]      depth_o,
  input logic                 busy_o
);
  assert_vec_map_R1: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req_o |-> vec_o == VEC_BASE + (ADDRW'(src_o) << VEC_SHIFT));

  assert_master_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req_o |-> $past(en_i[NSRC]));

  assert_src_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req_o |-> ((($past(req_i & en_i[NSRC-1:0])) >> src_o) & 1) == 1);

  assert_cmp_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req_o && src_o == IDXW'(NSRC - 1)) |-> !$past(busy_o));

  assert_on_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req_o |-> $past(boundary_i));

  assert_strict_nest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req_o && $past(busy_o)) |-> cur_lvl_o > $past(cur_lvl_o));

  assert_top_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cur_lvl_o == LVLW'(NLVL - 1)) |=> !vec_req_o);

  assert_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req_o |-> depth_o == $past(depth_o) + 1'b1);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    depth_o <= DEPW'(NLVL));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_o == '0) |-> (!busy_o && cur_lvl_o == '0));

  assert_reti_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reti_i) |-> !vec_req_o);
endmodule

bind prio_irq_ctrl irq_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_i      (req_i),
  .en_i       (en_i),
  .boundary_i (boundary_i),
  .reti_i     (reti_i),
  .vec_req_o  (vec_req_o),
  .src_o      (src_o),
  .vec_o      (vec_o),
  .cur_lvl_o  (cur_lvl_o),
  .depth_o    (depth_o),
  .busy_o     (busy_o)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  req;
  logic [7:0]  en;
  logic [5:0]  lo, hi;
  logic        boundary, reti;
  logic        vec_req;
  logic [2:0]  src;
  logic [15:0] vec;
  logic [1:0]  cur_lvl;
  logic [2:0]  depth;
  logic        busy;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int          src;
    logic [15:0] vec;
    string       tag;
  } exp_t;
  exp_t q[$];
  string cur_tag = "R10";

  always #2 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .en_i(en), .lo_i(lo), .hi_i(hi),
    .boundary_i(boundary), .reti_i(reti), .vec_req_o(vec_req), .src_o(src),
    .vec_o(vec), .cur_lvl_o(cur_lvl), .depth_o(depth), .busy_o(busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Monitor: pops the scoreboard whenever a vector request shows up
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (rst_n && vec_req) begin
      if (q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL %s unexpected vector actual_src=%0d expected=none", cur_tag, src);
      end else begin
        e = q.pop_front();
        chk({e.tag, " src"}, int'(src), e.src);
        chk({e.tag, " R1 vec"}, int'(vec), int'(e.vec));
      end
    end
  end

  // Driver: one boundary strobe with requests r; exp < 0 means no acceptance
  task automatic strobe(input logic [6:0] r, input int exp, input string tag);
    exp_t e;
    int   d0;
    d0       = int'(depth);
    cur_tag  = tag;
    req      = r;
    boundary = 1'b1;
    if (exp >= 0) begin
      e.src = exp;
      e.vec = 16'h0003 + 16'(exp * 8);
      e.tag = tag;
      q.push_back(e);
    end
    @(negedge clk);
    boundary = 1'b0;
    @(negedge clk);
    chk({tag, " R8 depth"}, int'(depth), d0 + ((exp >= 0) ? 1 : 0));
  endtask

  task automatic do_reti();
    reti = 1'b1;
    @(negedge clk);
    reti = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req = '0; en = '0; lo = '0; hi = '0;
    boundary = 1'b0; reti = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10 vec_req", int'(vec_req), 0);
    chk("R10 src", int'(src), 0);
    chk("R10 vec", int'(vec), 0);
    chk("R10 cur_lvl", int'(cur_lvl), 0);
    chk("R10 depth", int'(depth), 0);
    chk("R10 busy", int'(busy), 0);

    en = 8'hFF;
    // R5/R1: equal levels, lowest index wins; walks every vector
    for (int i = 0; i < 7; i++) begin
      strobe(7'h7F << i, i, "R5");
      do_reti();
      chk("R8 pop", int'(depth), 0);
    end

    // R2: master off, then individual enable off
    en = 8'h7F;
    strobe(7'h7F, -1, "R2");
    en = 8'hFE;
    strobe(7'h01, -1, "R2");
    strobe(7'h03, 1, "R2");
    do_reti();
    en = 8'hFF;

    // R3/R5: src4 level 3, src1 level 2, src2 level 1
    lo = 6'b010100;
    hi = 6'b010010;
    strobe(7'h7F, 4, "R5");
    chk("R8 cur_lvl", int'(cur_lvl), 3);
    strobe(7'h7F, -1, "R7");
    do_reti();
    strobe(7'h07, 1, "R5");
    do_reti();

    // R6: build a four-deep nest
    strobe(7'h01, 0, "R6");
    strobe(7'h40, -1, "R3");
    strobe(7'h08, -1, "R6");
    strobe(7'h04, 2, "R6");
    chk("R8 cur_lvl", int'(cur_lvl), 1);
    strobe(7'h07, 1, "R6");
    strobe(7'h17, 4, "R6");
    chk("R8 full depth", int'(depth), 4);
    chk("R8 busy", int'(busy), 1);
    chk("R8 cur_lvl", int'(cur_lvl), 3);
    strobe(7'h7F, -1, "R7");
    do_reti();
    chk("R8 restore", int'(cur_lvl), 2);
    strobe(7'h02, -1, "R6");
    do_reti();
    chk("R8 restore", int'(cur_lvl), 1);
    do_reti();
    chk("R8 restore", int'(cur_lvl), 0);
    chk("R8 depth", int'(depth), 1);

    // R9: return and strobe together
    cur_tag  = "R9";
    req      = 7'h10;
    reti     = 1'b1;
    boundary = 1'b1;
    @(negedge clk);
    reti     = 1'b0;
    boundary = 1'b0;
    @(negedge clk);
    chk("R9 depth", int'(depth), 0);
    chk("R9 busy", int'(busy), 0);

    // R4: requests without a strobe do nothing
    cur_tag = "R4";
    req     = 7'h7F;
    repeat (5) @(negedge clk);
    chk("R4 depth", int'(depth), 0);
    chk("R4 vec_req", int'(vec_req), 0);

    // R3: comparator taken when idle, at level 0
    strobe(7'h40, 6, "R3");
    chk("R3 cur_lvl", int'(cur_lvl), 0);
    do_reti();

    repeat (3) @(negedge clk);
    chk("scoreboard drained", q.size(), 0);
    finish_run();
  end
endmodule